// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block adds a doorbell interrupt path between the two ports of a shared memory. The two highest addresses of the port address space are reserved as message slots. The top address is the right port's inbox. The address just below it is the left port's inbox. When one port writes into the other port's inbox, that port's interrupt is raised. When the receiving port reads its own inbox, its interrupt is cleared. The block watches only the access strobes and addresses of both ports. The memory array that holds the message bytes lives elsewhere.

Each port drives an active-low chip enable, write strobe and output enable, an address, and an active-low busy flag from the port arbiter. When a port's busy flag is low, any set or clear action by that port is dropped. Each port gets its own active-low interrupt output. The interrupt state is registered: it changes on the clock edge that samples the qualifying access, and holds otherwise.

Top module: `mbx_irq_flags`

## Requirements
- R1: While rst_ni is low, and after it rises with no further access, both l_irq_no and r_irq_no are high.
- R2: A left access with l_cs_ni=0 and l_we_ni=0 at the all-ones address (0x3FFF for ADDR_W=14) drives r_irq_no low from the next clock edge.
- R3: A right access with r_cs_ni=0 and r_oe_ni=0 at the all-ones address drives r_irq_no high from the next clock edge. The value of r_we_ni does not matter.
- R4: A right access with r_cs_ni=0 and r_we_ni=0 at the all-ones address minus one (0x3FFE) drives l_irq_no low from the next clock edge.
- R5: A left access with l_cs_ni=0 and l_oe_ni=0 at the all-ones address minus one drives l_irq_no high from the next clock edge. The value of l_we_ni does not matter.
- R6: An access made while that port's busy input is low (0) neither sets nor clears any interrupt.
- R7: If a set and a clear of the same interrupt fall in the same cycle, the interrupt is asserted (low) after that edge.
- R8: Without a qualifying set or clear, each interrupt output holds its value. This covers accesses to other addresses, accesses with the chip enable high, a read of the peer's inbox, and a write to the port's own inbox with its output enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_ni | input | 1 | Left chip enable, active low |
| l_we_ni | input | 1 | Left write strobe, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_busy_ni | input | 1 | Left busy flag, active low |
| l_addr_i | input | ADDR_W | Left address |
| r_cs_ni | input | 1 | Right chip enable, active low |
| r_we_ni | input | 1 | Right write strobe, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_busy_ni | input | 1 | Right busy flag, active low |
| r_addr_i | input | ADDR_W | Right address |
| l_irq_no | output | 1 | Interrupt to left port, active low |
| r_irq_no | output | 1 | Interrupt to right port, active low |

## Verification
The assertions assume that every port input is synchronous to clk_i and settles before the sampling edge. They also assume that one clock period spans one complete access, so each access is sampled exactly once. The bench keeps to these assumptions: it changes inputs only on the falling edge and holds each access for a single full cycle. Between accesses it returns every port to idle, with all strobes high and busy inactive.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic busy_n;
  } port_ctl_t;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int unsigned         ADDR_W   = 14,
  parameter logic [ADDR_W-1:0]   PEER_BOX = '1,
  parameter logic [ADDR_W-1:0]   OWN_BOX  = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  mbx_pkg::port_ctl_t     ctl_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic                   set_peer_o,
  output logic                   clr_own_o
);
  logic active;
  assign active     = !ctl_i.cs_n && ctl_i.busy_n;
  assign set_peer_o = active && !ctl_i.we_n && (addr_i == PEER_BOX);
  // read clear: write strobe is don't-care
  assign clr_own_o  = active && !ctl_i.oe_n && (addr_i == OWN_BOX);

  p_busy_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.busy_n |-> !set_peer_o && !clr_own_o);
  p_set_is_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_peer_o |-> !ctl_i.cs_n && !ctl_i.we_n);
  p_clr_is_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_own_o |-> !ctl_i.cs_n && !ctl_i.oe_n);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign irq_no = !pend_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !irq_no);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> irq_no);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(irq_no));
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic              l_busy_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_cs_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic              r_busy_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_irq_no,
  output logic              r_irq_no
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX = R_BOX - 1'b1;

  port_ctl_t         ctl  [NUM_PORTS];
  logic [ADDR_W-1:0] addr [NUM_PORTS];
  logic              set  [NUM_PORTS];
  logic              clr  [NUM_PORTS];
  logic              irq_n[NUM_PORTS];

  assign ctl[PORT_L]  = '{cs_n: l_cs_ni, we_n: l_we_ni, oe_n: l_oe_ni, busy_n: l_busy_ni};
  assign ctl[PORT_R]  = '{cs_n: r_cs_ni, we_n: r_we_ni, oe_n: r_oe_ni, busy_n: r_busy_ni};
  assign addr[PORT_L] = l_addr_i;
  assign addr[PORT_R] = r_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == PORT_L) ? L_BOX : R_BOX;
    localparam logic [ADDR_W-1:0] PEER = (p == PORT_L) ? R_BOX : L_BOX;

    mbx_port_decode #(.ADDR_W(ADDR_W), .PEER_BOX(PEER), .OWN_BOX(OWN)) i_dec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_i      (ctl[p]),
      .addr_i     (addr[p]),
      .set_peer_o (set[p]),
      .clr_own_o  (clr[p])
    );

    // flag for port p is raised by the peer, cleared by p itself
    mbx_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set[NUM_PORTS-1-p]),
      .clr_i  (clr[p]),
      .irq_no (irq_n[p])
    );
  end

  assign l_irq_no = irq_n[PORT_L];
  assign r_irq_no = irq_n[PORT_R];

  p_left_write_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_cs_ni && !l_we_ni && l_busy_ni && l_addr_i == R_BOX |=> !r_irq_no);
  p_right_write_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_cs_ni && !r_we_ni && r_busy_ni && r_addr_i == L_BOX |=> !l_irq_no);
  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> l_irq_no && r_irq_no);
endmodule

// File: tb/test_mbx_irq_flags.sv
module test_mbx_irq_flags;
  localparam int unsigned AW = 14;
  localparam logic [AW-1:0] RBOX = 14'h3FFF;
  localparam logic [AW-1:0] LBOX = 14'h3FFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs = 1, l_we = 1, l_oe = 1, l_busy = 1;
  logic r_cs = 1, r_we = 1, r_oe = 1, r_busy = 1;
  logic [AW-1:0] l_a = '0, r_a = '0;
  logic l_irq, r_irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mbx_irq_flags #(.ADDR_W(AW)) i_mbx_irq_flags (
    .clk_i(clk), .rst_ni(rst_n),
    .l_cs_ni(l_cs), .l_we_ni(l_we), .l_oe_ni(l_oe), .l_busy_ni(l_busy), .l_addr_i(l_a),
    .r_cs_ni(r_cs), .r_we_ni(r_we), .r_oe_ni(r_oe), .r_busy_ni(r_busy), .r_addr_i(r_a),
    .l_irq_no(l_irq), .r_irq_no(r_irq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    l_cs = 1; l_we = 1; l_oe = 1; l_busy = 1; l_a = '0;
    r_cs = 1; r_we = 1; r_oe = 1; r_busy = 1; r_a = '0;
  endtask

  // drive at negedge; one edge samples it; back to idle at the next negedge
  task automatic drv_l(input logic cs, we, oe, busy, input logic [AW-1:0] a);
    l_cs = cs; l_we = we; l_oe = oe; l_busy = busy; l_a = a;
  endtask
  task automatic drv_r(input logic cs, we, oe, busy, input logic [AW-1:0] a);
    r_cs = cs; r_we = we; r_oe = oe; r_busy = busy; r_a = a;
  endtask
  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 left in reset", l_irq, 1'b1);
    chk("R1 right in reset", r_irq, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 left after reset", l_irq, 1'b1);
    chk("R1 right after reset", r_irq, 1'b1);
  endtask

  task automatic t_left_to_right();
    drv_l(0, 0, 1, 1, RBOX); step();
    chk("R2 right raised", r_irq, 1'b0);
    chk("R2 left untouched", l_irq, 1'b1);
    step();
    chk("R8 right held", r_irq, 1'b0);
    drv_r(0, 1, 0, 1, RBOX); step();
    chk("R3 right cleared", r_irq, 1'b1);
    drv_l(0, 0, 1, 1, RBOX); step();
    drv_r(0, 0, 0, 1, RBOX); step();
    chk("R3 clear with write strobe low", r_irq, 1'b1);
  endtask

  task automatic t_right_to_left();
    drv_r(0, 0, 1, 1, LBOX); step();
    chk("R4 left raised", l_irq, 1'b0);
    chk("R4 right untouched", r_irq, 1'b1);
    drv_l(0, 1, 0, 1, LBOX); step();
    chk("R5 left cleared", l_irq, 1'b1);
    drv_r(0, 0, 1, 1, LBOX); step();
    drv_l(0, 0, 0, 1, LBOX); step();
    chk("R5 clear with write strobe low", l_irq, 1'b1);
  endtask

  task automatic t_busy();
    drv_l(0, 0, 1, 0, RBOX); step();
    chk("R6 busy left write ignored", r_irq, 1'b1);
    drv_r(0, 0, 1, 1, LBOX); step();
    drv_l(0, 1, 0, 0, LBOX); step();
    chk("R6 busy left read ignored", l_irq, 1'b0);
    drv_l(0, 1, 0, 1, LBOX); step();
    chk("R6 normal clear after busy", l_irq, 1'b1);
  endtask

  task automatic t_priority();
    drv_l(0, 0, 1, 1, RBOX); drv_r(0, 1, 0, 1, RBOX); step();
    chk("R7 set wins from idle", r_irq, 1'b0);
    drv_l(0, 0, 1, 1, RBOX); drv_r(0, 1, 0, 1, RBOX); step();
    chk("R7 set wins when pending", r_irq, 1'b0);
    drv_r(0, 1, 0, 1, RBOX); step();
    chk("R7 cleared afterwards", r_irq, 1'b1);
  endtask

  task automatic t_hold();
    drv_l(0, 1, 0, 1, RBOX); step();
    chk("R8 read of peer box", r_irq, 1'b1);
    drv_l(0, 0, 1, 1, LBOX); step();
    chk("R8 write own box oe high", l_irq, 1'b1);
    chk("R8 write own box no peer", r_irq, 1'b1);
    drv_l(0, 0, 1, 1, 14'h3FFD); step();
    chk("R8 other address", r_irq, 1'b1);
    drv_l(1, 0, 1, 1, RBOX); step();
    chk("R8 chip enable high", r_irq, 1'b1);
    drv_r(0, 0, 1, 1, LBOX); step();
    drv_r(0, 1, 0, 1, 14'h0000); step();
    drv_l(0, 0, 1, 1, 14'h1234); step();
    chk("R8 pending held through traffic", l_irq, 1'b0);
  endtask

  initial begin
    idle();
    @(negedge clk); @(negedge clk);
    t_reset();
    t_left_to_right();
    t_right_to_left();
    t_busy();
    t_priority();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule